// File: doc/BRIEF.md
# UART Auto-Baud Bit-Period Meter

This block measures how long the incoming UART receive line stays in one level so that software can derive a baud divisor from the result. Software arms a measurement by writing the run bit of a single control word. The block then waits for the line to fall, counts prescaled clock ticks over a measurement window and latches the count into a divisor output. The window is selected by a mode bit: either the low time of the start bit, or a full fall-to-fall span that is halved.

A successful measurement clears the run bit, raises a sticky end flag and pulses a one-cycle done output. If the counter would pass its maximum value, a sticky time-out flag is raised instead. With the restart bit set, a time-out re-arms the block so that it waits for the next falling edge without software help. Each flag has a write-one clear bit and an interrupt enable. Writing 0 to the run bit while a measurement is in progress abandons it.

Top module: `autobaud_meter`

## Requirements
- R1: After reset, every control and status bit reads 0, the divisor output is 0, and both done and interrupt outputs are low.
- R2: Control word bits are run(0), mode(1), restart(2), end-clear(3), time-out-clear(4), end-irq-enable(5), time-out-irq-enable(6), with end flag(7) and time-out flag(8) read only. Writing 1 to run while idle arms the block, and run reads 1 while it is armed or counting. RX edges seen while idle do not start a measurement.
- R3: In mode 0, counting starts at the first RX falling edge after arming and stops at the next rising edge. The result is floor(L/PRESCALE), where L is the low time in clock cycles.
- R4: In mode 1, a rising edge does not end the window. Counting runs to the next falling edge, and the result is floor(L/PRESCALE)/2 (rounded down), where L is the fall-to-fall time.
- R5: On a successful measurement, four things update in the same clock edge: the divisor output is loaded, done goes high for exactly one cycle, run reads 0 and the end flag reads 1. The divisor changes at no other time.
- R6: If a tick arrives while the counter holds its all-ones value, the time-out flag is set. With restart 0, run reads 0 afterwards, the divisor is unchanged and done stays low.
- R7: With restart 1, a time-out leaves run at 1. The block waits for the next RX falling edge, and the measurement that follows completes normally.
- R8: Writing 1 to a clear bit clears its flag. Writing 0 leaves the flag unchanged. Clear bits always read 0. A flag-setting event in the same cycle as a clear wins.
- R9: irq_o is high exactly when a flag is set and its enable bit is 1.
- R10: Writing 0 to run while armed or counting aborts the measurement. Neither flag is set, done does not pulse and the divisor is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word write data |
| cfg_rdata | output | 9 | Control and status read data |
| rx_i | input | 1 | Asynchronous UART receive line |
| divisor_o | output | CNT_W | Last measured count |
| done_o | output | 1 | One-cycle pulse on measurement completion |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the restart path: the counter has to run all the way to its all-ones value, and a fresh edge must then be accepted while run stays high. The bench shrinks the counter width and the prescaler through parameters so that a time-out takes about two thousand cycles. It holds RX low through the time-out, then releases the line and drops it again. Finally it checks that the second measurement gives the expected divisor. Abort is reached by writing the run bit low mid-window and then completing the window, so that a wrong design would have produced a result.

// File: rtl/abd_pkg.sv
// Package: shared state encoding and control word bit positions for the
// auto-baud meter. Assumes a 9-bit control word.
package abd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } abd_state_t;

    localparam int CTRL_W     = 9;
    localparam int B_RUN      = 0;
    localparam int B_MODE     = 1;
    localparam int B_RESTART  = 2;
    localparam int B_EO_CLR   = 3;
    localparam int B_TO_CLR   = 4;
    localparam int B_EO_EN    = 5;
    localparam int B_TO_EN    = 6;
    localparam int B_EO_FLAG  = 7;
    localparam int B_TO_FLAG  = 8;
endpackage

// File: rtl/abd_rx_edge.sv
// Module: two-flop synchroniser plus edge detector for the RX line.
// Assumes the line idles high; flops reset to 1 so no edge is seen at reset.
module abd_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o,
    output logic rise_o
);
    logic s1_q, s2_q, prev_q;

    // Synchronise RX and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= rx_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign fall_o = prev_q & ~s2_q;
    assign rise_o = ~prev_q & s2_q;
endmodule

// File: rtl/abd_tick_gen.sv
// Module: prescaler producing one tick every PRESCALE enabled cycles.
// Assumes clr_i restarts the phase so the first tick lands PRESCALE cycles
// after the clear.
module abd_tick_gen #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick_o = en_i;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] phase_q;

            // Advance the phase while enabled, wrapping at the last value.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    phase_q <= '0;
                else if (en_i)
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end

            assign tick_o = en_i && (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/abd_measure.sv
// Module: measurement sequencer and tick counter. Waits for a falling edge,
// counts ticks until the window-ending edge for the latched mode, and
// reports completion or overflow as single-cycle events.
// Assumes start_i only arrives while idle and abort_i only while busy.
module abd_measure
    import abd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             mode_i,
    input  logic             restart_i,
    input  logic             fall_i,
    input  logic             rise_i,
    output logic             busy_o,
    output logic             done_ev_o,
    output logic             tmo_ev_o,
    output logic [CNT_W-1:0] result_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    abd_state_t       state_q;
    logic             mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             counting;
    logic             end_edge;
    logic             ovf;
    logic [CNT_W-1:0] cnt_inc;

    assign counting = (state_q == ST_COUNT);

    abd_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_q == ST_ARMED && fall_i),
        .en_i  (counting),
        .tick_o(tick)
    );

    // Window end, overflow detection and the value the result would take.
    always_comb begin
        end_edge  = mode_q ? fall_i : rise_i;
        ovf       = counting && tick && (cnt_q == CNT_MAX);
        cnt_inc   = cnt_q + {{(CNT_W-1){1'b0}}, tick};
        done_ev_o = counting && !abort_i && !ovf && end_edge;
        tmo_ev_o  = counting && !abort_i && ovf;
        result_o  = mode_q ? (cnt_inc >> 1) : cnt_inc;
    end

    assign busy_o = (state_q != ST_IDLE);

    // Sequencer: idle, waiting for the start edge, counting the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (abort_i) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_ARMED;
                        mode_q  <= mode_i;
                    end
                end
                ST_ARMED: begin
                    if (fall_i) begin
                        state_q <= ST_COUNT;
                        cnt_q   <= '0;
                    end
                end
                ST_COUNT: begin
                    if (tmo_ev_o)
                        state_q <= restart_i ? ST_ARMED : ST_IDLE;
                    else if (done_ev_o)
                        state_q <= ST_IDLE;
                    else
                        cnt_q <= cnt_inc;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/autobaud_meter.sv
// Module: top of the auto-baud meter. Holds the control word, the sticky
// flags, the divisor register and the interrupt, around the edge detector
// and measurement sequencer.
// Assumes one control word write per cycle; clear bits act only as strobes.
module autobaud_meter
    import abd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [8:0]       cfg_wdata,
    output logic [8:0]       cfg_rdata,
    input  logic             rx_i,
    output logic [CNT_W-1:0] divisor_o,
    output logic             done_o,
    output logic             irq_o
);
    logic             fall, rise;
    logic             busy, done_ev, tmo_ev;
    logic [CNT_W-1:0] result;
    logic             mode_q, restart_q, eo_en_q, to_en_q;
    logic             eo_flag_q, to_flag_q;
    logic             start, abort;

    assign start = cfg_we &&  cfg_wdata[B_RUN] && !busy;
    assign abort = cfg_we && !cfg_wdata[B_RUN] &&  busy;

    abd_rx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_i  (rx_i),
        .fall_o(fall),
        .rise_o(rise)
    );

    abd_measure #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .abort_i  (abort),
        .mode_i   (cfg_wdata[B_MODE]),
        .restart_i(restart_q),
        .fall_i   (fall),
        .rise_i   (rise),
        .busy_o   (busy),
        .done_ev_o(done_ev),
        .tmo_ev_o (tmo_ev),
        .result_o (result)
    );

    // Configuration bits: loaded on every control word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            restart_q <= 1'b0;
            eo_en_q   <= 1'b0;
            to_en_q   <= 1'b0;
        end else if (cfg_we) begin
            mode_q    <= cfg_wdata[B_MODE];
            restart_q <= cfg_wdata[B_RESTART];
            eo_en_q   <= cfg_wdata[B_EO_EN];
            to_en_q   <= cfg_wdata[B_TO_EN];
        end
    end

    // Sticky flags: set by events, cleared by write-one strobes; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eo_flag_q <= 1'b0;
            to_flag_q <= 1'b0;
        end else begin
            if (done_ev)
                eo_flag_q <= 1'b1;
            else if (cfg_we && cfg_wdata[B_EO_CLR])
                eo_flag_q <= 1'b0;
            if (tmo_ev)
                to_flag_q <= 1'b1;
            else if (cfg_we && cfg_wdata[B_TO_CLR])
                to_flag_q <= 1'b0;
        end
    end

    // Divisor register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= done_ev;
            if (done_ev)
                divisor_o <= result;
        end
    end

    // Read view of the control word; clear strobes read back as 0.
    always_comb begin
        cfg_rdata            = '0;
        cfg_rdata[B_RUN]     = busy;
        cfg_rdata[B_MODE]    = mode_q;
        cfg_rdata[B_RESTART] = restart_q;
        cfg_rdata[B_EO_EN]   = eo_en_q;
        cfg_rdata[B_TO_EN]   = to_en_q;
        cfg_rdata[B_EO_FLAG] = eo_flag_q;
        cfg_rdata[B_TO_FLAG] = to_flag_q;
    end

    assign irq_o = (eo_flag_q && eo_en_q) || (to_flag_q && to_en_q);
endmodule

// File: rtl/abd_checker.sv
// Module: temporal properties of the auto-baud meter, observed at its ports.
// Assumes rst_n is held low for at least two clocks at start-up.
module abd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             restart_i,
    input logic             eo_flag_i,
    input logic             to_flag_i,
    input logic [CNT_W-1:0] divisor_i,
    input logic             done_i,
    input logic             irq_i
);
    // R5: completion leaves the run bit low.
    p_done_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> !run_i);

    // R5: completion raises the end flag.
    p_done_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> eo_flag_i);

    // R5: done is a single-cycle pulse.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    // R5: the divisor only changes together with done.
    p_divisor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |-> $stable(divisor_i));

    // R6 and R7: after a time-out, run follows the restart setting.
    p_timeout_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag_i) |-> (run_i == $past(restart_i)));

    // R9: an interrupt only rises when some flag is set.
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_i) |-> (eo_flag_i || to_flag_i));
endmodule

bind autobaud_meter abd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (cfg_rdata[0]),
    .restart_i(cfg_rdata[2]),
    .eo_flag_i(cfg_rdata[7]),
    .to_flag_i(cfg_rdata[8]),
    .divisor_i(divisor_o),
    .done_i   (done_o),
    .irq_i    (irq_o)
);

// File: tb/autobaud_meter_tb.sv
module autobaud_meter_tb;
    localparam int CNT_W = 10;
    localparam int PRESC = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [8:0]       cfg_wdata = '0;
    logic [8:0]       cfg_rdata;
    logic             rx = 1'b1;
    logic [CNT_W-1:0] divisor;
    logic             done;
    logic             irq;

    int total = 0;
    int fails = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    autobaud_meter #(.CNT_W(CNT_W), .PRESCALE(PRESC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_i(rx), .divisor_o(divisor),
        .done_o(done), .irq_o(irq)
    );

    always @(negedge clk) if (done) done_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit run, input bit mode, input bit rs, input bit eoc,
                      input bit toc, input bit eoe, input bit toe);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {2'b00, toe, eoe, toc, eoc, rs, mode, run};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic low_pulse(input int len);
        rx = 1'b0;
        repeat (len) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cfg_rdata == 9'd0, "R1 rdata", cfg_rdata, 0);
        chk(divisor == 0, "R1 divisor", divisor, 0);
        chk(!done && !irq, "R1 done/irq", {done, irq}, 0);
    endtask

    task automatic t_idle_ignore();
        low_pulse(20);
        settle();
        chk(cfg_rdata[0] == 1'b0, "R2 idle edges", cfg_rdata[0], 0);
        chk(done_cnt == 0, "R2 no done", done_cnt, 0);
    endtask

    task automatic t_mode0(input int len, input int exp);
        int d0;
        d0 = done_cnt;
        wr(1, 0, 0, 1, 1, 0, 0);
        chk(cfg_rdata[0] == 1'b1, "R2 run reads 1", cfg_rdata[0], 1);
        repeat (3) @(negedge clk);
        low_pulse(len);
        settle();
        chk(divisor == exp, "R3 mode0 divisor", divisor, exp);
        chk(done_cnt == d0 + 1, "R5 one done pulse", done_cnt - d0, 1);
        chk(cfg_rdata[0] == 1'b0, "R5 run cleared", cfg_rdata[0], 0);
        chk(cfg_rdata[7] == 1'b1, "R5 end flag", cfg_rdata[7], 1);
    endtask

    task automatic t_mode1();
        wr(1, 1, 0, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        low_pulse(20);
        repeat (20) @(negedge clk);
        chk(cfg_rdata[0] == 1'b1, "R4 rise ignored", cfg_rdata[0], 1);
        rx = 1'b0;
        settle();
        chk(divisor == 10, "R4 mode1 divisor", divisor, 10);
        rx = 1'b1;
        settle();
    endtask

    task automatic t_clear_irq();
        wr(0, 0, 0, 0, 0, 1, 0);
        chk(irq == 1'b1, "R9 irq on", irq, 1);
        chk(cfg_rdata[7] == 1'b1, "R8 zero write keeps flag", cfg_rdata[7], 1);
        wr(0, 0, 0, 0, 0, 0, 0);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        wr(0, 0, 0, 1, 0, 1, 0);
        chk(cfg_rdata[7] == 1'b0, "R8 clear", cfg_rdata[7], 0);
        chk(cfg_rdata[4:3] == 2'b00, "R8 clear bits read 0", cfg_rdata[4:3], 0);
        chk(irq == 1'b0, "R9 irq off", irq, 0);
    endtask

    task automatic t_timeout();
        int d0;
        logic [CNT_W-1:0] dv;
        d0 = done_cnt;
        dv = divisor;
        wr(1, 0, 0, 0, 0, 0, 1);
        rx = 1'b0;
        repeat (3000) @(negedge clk);
        chk(cfg_rdata[8] == 1'b1, "R6 timeout flag", cfg_rdata[8], 1);
        chk(cfg_rdata[0] == 1'b0, "R6 run cleared", cfg_rdata[0], 0);
        chk(divisor == dv && done_cnt == d0, "R6 divisor kept", divisor, dv);
        chk(irq == 1'b1, "R9 timeout irq", irq, 1);
        rx = 1'b1;
        settle();
        wr(0, 0, 0, 0, 1, 0, 1);
        chk(cfg_rdata[8] == 1'b0 && irq == 1'b0, "R8 timeout clear", cfg_rdata[8], 0);
    endtask

    task automatic t_restart();
        wr(1, 0, 1, 0, 0, 0, 0);
        rx = 1'b0;
        repeat (3000) @(negedge clk);
        chk(cfg_rdata[8] == 1'b1, "R7 timeout flag", cfg_rdata[8], 1);
        chk(cfg_rdata[0] == 1'b1, "R7 run stays", cfg_rdata[0], 1);
        rx = 1'b1;
        settle();
        low_pulse(30);
        settle();
        chk(divisor == 15, "R7 remeasure divisor", divisor, 15);
        chk(cfg_rdata[0] == 1'b0, "R7 run cleared", cfg_rdata[0], 0);
        wr(0, 0, 0, 1, 1, 0, 0);
    endtask

    task automatic t_abort();
        int d0;
        logic [CNT_W-1:0] dv;
        d0 = done_cnt;
        dv = divisor;
        wr(1, 0, 0, 0, 0, 0, 0);
        rx = 1'b0;
        repeat (10) @(negedge clk);
        wr(0, 0, 0, 0, 0, 0, 0);
        chk(cfg_rdata[0] == 1'b0, "R10 run cleared", cfg_rdata[0], 0);
        repeat (10) @(negedge clk);
        rx = 1'b1;
        settle();
        chk(done_cnt == d0, "R10 no done", done_cnt - d0, 0);
        chk(cfg_rdata[8:7] == 2'b00, "R10 no flags", cfg_rdata[8:7], 0);
        chk(divisor == dv, "R10 divisor kept", divisor, dv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_mode0(40, 20);
        t_mode0(33, 16);
        t_mode1();
        t_clear_irq();
        t_timeout();
        t_restart();
        t_abort();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule